// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement integers of a parameterised width using radix-2 Booth recoding, one recoding step per clock cycle. A start pulse captures both operands while the unit is idle. Over the next WIDTH cycles, the unit looks at the low bit of the multiplier register and the bit that was shifted out of it. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the accumulator, the multiplier register and the spare bit right by one position, copying the sign bit into the vacated position.

The accumulator has one guard bit above the operand width, so negating the most negative multiplicand cannot wrap. When the last step completes, the registered product is updated and a one-cycle done pulse is raised. The product is the concatenation of the accumulator, without its guard bit, and the multiplier register. A start that arrives while a multiplication is running is dropped.

Top module: `booth_mul_seq`

## Requirements
- R1: After synchronous reset, done_o is 0 and product_o is all zeros.
- R2: A start_i seen high at a rising edge while idle is accepted. done_o is high for exactly one cycle, following the WIDTH-th rising edge after the accepting edge.
- R3: For operands of mixed or equal signs, product_o equals the 2*WIDTH-bit two's-complement product of op_a_i and op_b_i. In each step, a recoding pair (multiplier LSB, previous bit) of 01 adds the multiplicand, 10 subtracts it, and 00 or 11 leaves the accumulator unchanged.
- R4: The most negative value times itself gives +2^(2*WIDTH-2), which is 16'h4000 for WIDTH=8.
- R5: The most negative value times -1, in either operand order, gives +2^(WIDTH-1), which is 16'h0080 for WIDTH=8.
- R6: A zero in either operand gives a zero product.
- R7: A start_i pulse during a running multiplication has no effect. The running result is unchanged and no extra done_o pulse appears.
- R8: product_o changes only in the cycle in which done_o is high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled at the rising edge |
| op_a_i | input | WIDTH | Multiplicand, two's complement |
| op_b_i | input | WIDTH | Multiplier, two's complement |
| done_o | output | 1 | One-cycle pulse when product_o is updated |
| product_o | output | 2*WIDTH | Registered signed product |

## Verification
The corner operands are chosen to separate the failure modes. The most negative value squared and times -1 expose a missing guard bit or a logical shift used in place of an arithmetic one. Zero operands and small positive pairs confirm that the no-operation recoding pairs leave the accumulator untouched. A pseudo-random run of mixed signs exercises every pattern of recoding pairs against a signed reference product. A second start issued mid-run, with different operands, would show up as a wrong result or a spurious done pulse if it were accepted. Done timing is compared with the accepting edge on every operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // pair = {multiplier LSB, previously shifted-out bit}
  function automatic booth_op_e booth_decode(input logic [1:0] pair);
    case (pair)
      2'b01:   return OP_ADD;
      2'b10:   return OP_SUB;
      default: return OP_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/booth_mul_step.sv
module booth_mul_step
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   acc_i,
  input  logic [WIDTH-1:0] mplr_i,
  input  logic             tail_i,
  input  logic [WIDTH:0]   mcand_i,
  output logic [WIDTH:0]   acc_o,
  output logic [WIDTH-1:0] mplr_o,
  output logic             tail_o
);
  booth_op_e      op;
  logic [WIDTH:0] sum;

  always_comb begin
    op = booth_decode({mplr_i[0], tail_i});
    case (op)
      OP_ADD:  sum = acc_i + mcand_i;
      OP_SUB:  sum = acc_i - mcand_i;
      default: sum = acc_i;
    endcase
    // arithmetic right shift of {sum, multiplier, tail}
    acc_o  = {sum[WIDTH], sum[WIDTH:1]};
    mplr_o = {sum[0], mplr_i[WIDTH-1:1]};
    tail_o = mplr_i[0];
  end
endmodule

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [CNT_W-1:0] count_q;
  logic             busy_q;
  logic             done_q;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign last_o   = busy_q && (count_q == CNT_W'(1));
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        count_q <= CNT_W'(WIDTH);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        count_q <= count_q - CNT_W'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R2

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && !busy_q)); // R2

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (count_q != '0)); // R2
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   op_a_i,
  input  logic [WIDTH-1:0]   op_b_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic accept, busy, last;

  logic [WIDTH:0]   acc_q, acc_n, mcand_q;
  logic [WIDTH-1:0] mplr_q, mplr_n;
  logic             tail_q, tail_n;
  logic [PW-1:0]    product_q;

  booth_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .accept_o(accept), .busy_o(busy), .last_o(last), .done_o(done_o)
  );

  booth_mul_step #(.WIDTH(WIDTH)) u_step (
    .acc_i(acc_q), .mplr_i(mplr_q), .tail_i(tail_q), .mcand_i(mcand_q),
    .acc_o(acc_n), .mplr_o(mplr_n), .tail_o(tail_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      mplr_q    <= '0;
      tail_q    <= 1'b0;
      mcand_q   <= '0;
      product_q <= '0;
    end else if (accept) begin
      acc_q   <= '0;
      mplr_q  <= op_b_i;
      tail_q  <= 1'b0;
      mcand_q <= {op_a_i[WIDTH-1], op_a_i};
    end else if (busy) begin
      acc_q  <= acc_n;
      mplr_q <= mplr_n;
      tail_q <= tail_n;
      if (last) product_q <= {acc_n[WIDTH-1:0], mplr_n};
    end
  end

  assign product_o = product_q;

  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mcand_q)); // R7

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R8
endmodule

// File: tb/booth_mul_seq_bench.sv
module booth_mul_seq_bench;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  typedef struct {
    logic [PW-1:0] prod;
    int            due;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  op_a_i = '0, op_b_i = '0;
  logic          done_o;
  logic [PW-1:0] product_o;

  int checks = 0, errors = 0, cyc = 0;
  exp_t q[$];
  logic [PW-1:0] last_prod = '0;
  bit running = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  booth_mul_seq #(.WIDTH(W)) u_booth_mul_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic signed [W-1:0]  sa, sb;
    logic signed [PW-1:0] p;
    exp_t e;
    while (q.size() != 0) @(negedge clk);
    sa = a; sb = b;
    p = sa * sb;
    e.prod = p; e.due = cyc + 1 + W; e.tag = tag;
    q.push_back(e);
    op_a_i = a; op_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (done_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected done", product_o, last_prod);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(product_o == e.prod, e.tag, product_o, e.prod);
          check(cyc == e.due, "R2 done timing", PW'(cyc), PW'(e.due));
        end
        last_prod = product_o;
      end else begin
        check(product_o == last_prod, "R8 product held", product_o, last_prod);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(done_o == 1'b0 && product_o == '0, "R1 reset state", {15'd0, done_o} | product_o, '0);
    running = 1'b1;

    run_op(8'h80, 8'h80, "R4 min*min");
    run_op(8'h80, 8'hFF, "R5 min*-1");
    run_op(8'hFF, 8'h80, "R5 -1*min");
    run_op(8'h00, 8'h80, "R6 zero*min");
    run_op(8'h7F, 8'h00, "R6 max*zero");
    run_op(8'h05, 8'h07, "R3 pos*pos");
    run_op(8'hF3, 8'h0B, "R3 neg*pos");
    run_op(8'h19, 8'hE7, "R3 pos*neg");
    run_op(8'h81, 8'h81, "R3 neg*neg");
    run_op(8'h7F, 8'h7F, "R3 max*max");

    // R7: second start while busy must be dropped
    run_op(8'h0D, 8'hF5, "R7 running result");
    repeat (3) @(negedge clk);
    op_a_i = 8'h55; op_b_i = 8'h33; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2 * W) @(negedge clk);

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 24; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_op(lfsr[7:0], lfsr[15:8], "R3 mixed run");
      end
    end
    while (q.size() != 0) @(negedge clk);
    repeat (W + 4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule